// File: doc/BRIEF.md
# Voltage-ID Serial Command Receiver

This block listens on a two-wire voltage-identification bus, made of a clock line and a data line, and decodes the commands that a processor sends to its voltage regulator. Both lines go through a synchronizer into the system clock domain. The receiver looks for start and stop conditions and collects the 27 clocked bit positions of a command. A command is three bytes, and each byte is followed by an acknowledge slot. The receiver checks the fixed address pattern and then extracts the regulator settings: the domain selects, an 8-bit VID, two active-low power-state hints, a telemetry enable, a load-line trim and an offset trim.

The decoded settings are held on registered outputs, and they change only once the stop condition has been seen. In that same cycle the block pulses a one-cycle valid strobe for each domain that the command selected, core or northbridge. The receiver is passive. It never drives the data line, and an acknowledge slot is simply clocked in and discarded.

Top module: `vid_cmd_rx`

## Requirements
- R1: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. Data bits are sampled on each rising edge of the clock line.
- R2: A command updates outputs only if clocked positions 1..5 read 1,1,0,0,0 in that order and position 8 reads 0. Any other value leaves every output unchanged and issues no strobe.
- R3: Position 6 set pulses `core_valid`, and position 7 set pulses `nb_valid`. Both set pulses both strobes. If neither is set, no output changes.
- R4: The field positions are as follows. Position 10 is `psi0_n`. Positions 11..17 are VID[7:1], with the MSB first. Position 19 is VID[0]. Position 20 is `psi1_n`. Position 21 is `tlm_en`. Positions 22..24 are `ll_trim[2:0]`, with the MSB first. Positions 25..26 are `ofs_trim[1:0]`, with the MSB first. Positions 9, 18 and 27 are ignored.
- R5: `svd_oe` is 0 at all times.
- R6: Outputs and strobes change only after the stop of a complete 27-bit command. Once the last bit has arrived and before the stop, the outputs still hold their old values. Each strobe lasts exactly one cycle.
- R7: A start received mid-command discards the bits collected so far and begins a new 27-bit command.
- R8: A stop received after fewer than 27 bits discards the partial command, with no output change and no strobe.
- R9: After reset, `vid` equals the VID_RST parameter (default 0). `psi0_n` and `psi1_n` are 1, `tlm_en`, `ll_trim` and `ofs_trim` are 0, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| svc_in | input | 1 | Bus clock line, asynchronous |
| svd_in | input | 1 | Bus data line, asynchronous |
| svd_oe | output | 1 | Data line output enable, held low |
| core_valid | output | 1 | One-cycle strobe: a command applied to the core domain |
| nb_valid | output | 1 | One-cycle strobe: a command applied to the northbridge domain |
| vid | output | 8 | Latched voltage ID |
| psi0_n | output | 1 | Latched power-state hint 0, active low |
| psi1_n | output | 1 | Latched power-state hint 1, active low |
| tlm_en | output | 1 | Latched telemetry enable |
| ll_trim | output | 3 | Latched load-line trim |
| ofs_trim | output | 2 | Latched offset trim |

## Verification
The bench sends complete commands that select the core domain only, the northbridge domain only, or both. These use asymmetric field values, such as a VID whose bit 0 differs from its neighbours and trims that are not palindromes, so that a shifted or swapped bit position gives a wrong value. Commands that select no domain, commands with a corrupted header bit or a corrupted position 8, and commands cut short by an early stop must all leave the outputs untouched. A command interrupted by a new start shows whether the bit counter restarts. The bench also stops just before the stop condition to confirm that nothing is applied on the final data bit alone.

// File: rtl/vid_cmd_rx.sv
module vid_cmd_rx #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] VID_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_in,
  input  logic       svd_in,
  output logic       svd_oe,
  output logic       core_valid,
  output logic       nb_valid,
  output logic [7:0] vid,
  output logic       psi0_n,
  output logic       psi1_n,
  output logic       tlm_en,
  output logic [2:0] ll_trim,
  output logic [1:0] ofs_trim
);
  localparam int NBITS = 27;
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] FULL = CW'(NBITS);

  logic [SYNC_STAGES:0] c_p, d_p;
  logic c_s, c_q, d_s, d_q;
  logic start_det, stop_det, rise;
  logic active;
  logic [CW-1:0] cnt;
  logic [NBITS-1:0] sh;
  logic addr_ok, sel_any;

  assign svd_oe = 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_p <= '1;
      d_p <= '1;
    end else begin
      c_p <= {c_p[SYNC_STAGES-1:0], svc_in};
      d_p <= {d_p[SYNC_STAGES-1:0], svd_in};
    end

  assign c_s = c_p[SYNC_STAGES-1];
  assign c_q = c_p[SYNC_STAGES];
  assign d_s = d_p[SYNC_STAGES-1];
  assign d_q = d_p[SYNC_STAGES];

  assign start_det = c_s & c_q & d_q & ~d_s;
  assign stop_det  = c_s & c_q & ~d_q & d_s;
  assign rise      = c_s & ~c_q;

  // position p (1-based) sits at sh[NBITS-p] once the frame is full
  assign addr_ok = (sh[26:22] == 5'b11000) & ~sh[19];
  assign sel_any = sh[21] | sh[20];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      core_valid <= 1'b0;
      nb_valid   <= 1'b0;
      vid        <= VID_RST;
      psi0_n     <= 1'b1;
      psi1_n     <= 1'b1;
      tlm_en     <= 1'b0;
      ll_trim    <= '0;
      ofs_trim   <= '0;
    end else begin
      core_valid <= 1'b0;
      nb_valid   <= 1'b0;
      if (start_det) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (stop_det) begin
        active <= 1'b0;
        cnt    <= '0;
        if (active && cnt == FULL && addr_ok && sel_any) begin
          core_valid <= sh[21];
          nb_valid   <= sh[20];
          psi0_n     <= sh[17];
          vid        <= {sh[16:10], sh[8]};
          psi1_n     <= sh[7];
          tlm_en     <= sh[6];
          ll_trim    <= sh[5:3];
          ofs_trim   <= sh[2:1];
        end
      end else if (rise && active && cnt != FULL) begin
        sh  <= {sh[NBITS-2:0], d_s};
        cnt <= cnt + 1'b1;
      end
    end

  assert_core_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |=> !core_valid);
  assert_nb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nb_valid |=> !nb_valid);
  assert_strobe_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid || nb_valid) |-> $past(stop_det) && $past(cnt) == FULL);
  assert_fields_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({vid, psi0_n, psi1_n, tlm_en, ll_trim, ofs_trim}) |-> (core_valid || nb_valid));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> cnt == '0 && active);
endmodule

// File: tb/vid_cmd_rx_test.sv
module vid_cmd_rx_test;
  typedef struct packed {
    logic       core, nb;
    logic [7:0] vid;
    logic       p0, p1, t;
    logic [2:0] ll;
    logic [1:0] o;
  } item_t;

  logic clk = 0, rst_n = 0, svc = 1, svd = 1;
  logic svd_oe, core_valid, nb_valid, psi0_n, psi1_n, tlm_en;
  logic [7:0] vid;
  logic [2:0] ll_trim;
  logic [1:0] ofs_trim;
  int errors = 0, checks = 0;
  item_t q[$];
  item_t cur;

  always #2.5 clk = ~clk;

  vid_cmd_rx uut (.clk, .rst_n, .svc_in(svc), .svd_in(svd), .svd_oe, .core_valid,
    .nb_valid, .vid, .psi0_n, .psi1_n, .tlm_en, .ll_trim, .ofs_trim);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic item_t outs();
    return '{core: 1'b0, nb: 1'b0, vid: vid, p0: psi0_n, p1: psi1_n, t: tlm_en,
             ll: ll_trim, o: ofs_trim};
  endfunction

  always @(negedge clk)
    if (rst_n && (core_valid || nb_valid)) begin
      item_t a, e;
      a = outs();
      a.core = core_valid;
      a.nb = nb_valid;
      if (q.size() == 0) chk(0, "R6 unexpected strobe", 32'(a), 0);
      else begin
        e = q.pop_front();
        chk(a == e, "R3/R4 strobe and fields", 32'(a), 32'(e));
      end
    end

  task automatic w(); repeat (6) @(posedge clk); endtask
  task automatic start_c(); svd = 1; w(); svc = 1; w(); svd = 0; w(); svc = 0; w(); endtask
  task automatic stop_c(); svd = 0; w(); svc = 1; w(); svd = 1; w(); endtask
  task automatic send(logic [26:0] f, int n);
    for (int i = 0; i < n; i++) begin
      svd = f[26-i]; w(); svc = 1; w(); svc = 0; w();
    end
  endtask

  function automatic logic [26:0] mk(item_t it, logic [4:0] hdr, logic b8);
    return {hdr, it.core, it.nb, b8, 1'b1, it.p0, it.vid[7:1], 1'b1, it.vid[0],
            it.p1, it.t, it.ll, it.o, 1'b1};
  endfunction

  task automatic hold(string tag);
    @(negedge clk);
    chk(outs() == cur, tag, 32'(outs()), 32'(cur));
  endtask

  task automatic good(item_t it, string tag);
    start_c(); send(mk(it, 5'b11000, 1'b0), 27);
    q.push_back(it);
    stop_c(); w();
    cur = it; cur.core = 0; cur.nb = 0;
    hold(tag);
    chk(q.size() == 0, {tag, " strobe seen"}, q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    item_t it;
    repeat (4) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    cur = '{core: 0, nb: 0, vid: 8'h00, p0: 1, p1: 1, t: 0, ll: 0, o: 0};
    hold("R9 reset defaults");
    chk(!core_valid && !nb_valid, "R9 strobes low", {core_valid, nb_valid}, 0);

    good('{core: 1, nb: 0, vid: 8'hA6, p0: 0, p1: 1, t: 1, ll: 3'b110, o: 2'b01}, "R1 R4 core");
    good('{core: 0, nb: 1, vid: 8'h3B, p0: 1, p1: 0, t: 0, ll: 3'b001, o: 2'b10}, "R3 nb");
    good('{core: 1, nb: 1, vid: 8'h01, p0: 0, p1: 0, t: 1, ll: 3'b011, o: 2'b11}, "R3 both");
    good('{core: 1, nb: 0, vid: 8'hFE, p0: 1, p1: 1, t: 0, ll: 3'b100, o: 2'b00}, "R4 vid0 split");

    it = '{core: 0, nb: 0, vid: 8'h55, p0: 0, p1: 0, t: 1, ll: 3'b111, o: 2'b11};
    start_c(); send(mk(it, 5'b11000, 0), 27); stop_c(); w();
    hold("R3 no domain ignored");

    it = '{core: 1, nb: 1, vid: 8'h55, p0: 0, p1: 0, t: 1, ll: 3'b111, o: 2'b11};
    start_c(); send(mk(it, 5'b11010, 0), 27); stop_c(); w();
    hold("R2 bad header ignored");
    start_c(); send(mk(it, 5'b11000, 1), 27); stop_c(); w();
    hold("R2 bit8 set ignored");

    start_c(); send(mk(it, 5'b11000, 0), 20); stop_c(); w();
    hold("R8 short command ignored");

    start_c(); send(mk(it, 5'b11000, 0), 27); w();
    hold("R6 no update before stop");
    chk(!core_valid && !nb_valid, "R6 no strobe before stop", {core_valid, nb_valid}, 0);
    q.push_back(it);
    stop_c(); w();
    cur = it; cur.core = 0; cur.nb = 0;
    hold("R6 applied after stop");

    it = '{core: 1, nb: 0, vid: 8'h9C, p0: 1, p1: 0, t: 0, ll: 3'b010, o: 2'b10};
    start_c(); send(27'h5A5A5A5, 12);
    svc = 1; w(); svd = 0; w(); svc = 0; w();
    send(mk(it, 5'b11000, 0), 27);
    q.push_back(it);
    stop_c(); w();
    cur = it; cur.core = 0; cur.nb = 0;
    hold("R7 restart mid-command");

    chk(svd_oe == 0, "R5 oe low", svd_oe, 0);
    chk(q.size() == 0, "R3 all strobes seen", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(negedge clk)
    if (rst_n && svd_oe !== 1'b0) chk(0, "R5 oe driven", svd_oe, 0);
endmodule